// File: doc/BRIEF.md
# Battery charge sequencer

This block sequences the charging of a two-cell lithium pack. It takes measurements that have already been digitized: supply voltage, battery voltage and charge current in mV and mA, and battery temperature as a signed count of 0.1 °C. It also takes four flags: main power on, DC plug present, DC voltage present and battery type confirmed. From these it selects a charge-current setpoint, drives an LED pattern and reports a latched error code. Analog regulation and conversion are handled elsewhere.

While idle, the block waits until the start conditions hold. It then runs two voltage-gated trickle phases, followed by a 666 mA quick phase. When the current tapers, it moves to a supplementary top-up phase and then to a done state. Every charging phase has its own maximum time, and one overall timer covers the whole charge. Every comparison of inputs has to agree for FILT consecutive clock samples (4 by default) before the state moves, so short noise spikes do not cause transitions. Timer expiries act at once.

Top module: `charge_sequencer`

## Requirements
- R1: After reset, `isel`, `led` and `err_code` are all 0 (idle).
- R2: From idle, the block enters trickle 1 (`isel`=1, `led`=1) when all of the following hold: main power is off, DC is plugged, DC voltage is present, supply is 8030..8800 mV inclusive, temperature is -67..494 (0.1 °C) inclusive, and the battery type is confirmed.
- R3: From idle, with power off and DC plugged and present, two cases raise an error. A supply outside 8030..8800 mV latches `err_code`=1. Otherwise, an unconfirmed battery type latches `err_code`=2. A temperature outside the start window alone leaves the block idle with `err_code`=0.
- R4: A state change caused by an input comparison happens on the FILT-th consecutive clock sample that calls for the same change. Any break in that run restarts the count.
- R5: Trickle 1 moves to trickle 2 (`isel`=2, `led`=1) when the battery is at or above 5200 mV. Trickle 2 moves to quick (`isel`=3, `led`=2) when the battery is at or above 6500 mV.
- R6: Quick moves to supplementary (`isel`=4, `led`=3) when the current is at or below 68 mA. Supplementary moves to done (`isel`=0, `led`=3) when the current is at or below 33 mA.
- R7: Each trickle phase has a limit: T1_MIN minutes for trickle 1 and T2_MIN minutes for trickle 2. Reaching that limit latches `err_code`=3.
- R8: When the quick phase reaches TQ_MIN minutes, the block moves to supplementary without an error. When supplementary reaches TS_MIN minutes, the block moves to done.
- R9: The total charge time counts from the entry into trickle 1. When it reaches TOT_MIN minutes, the block moves to done if it is in supplementary. In any other charging phase it latches `err_code`=3.
- R10: In quick or supplementary, a battery voltage at or below 5700 mV latches `err_code`=4.
- R11: In any charging phase, a temperature outside -101..556 (0.1 °C) latches `err_code`=5.
- R12: While an error is latched, `isel`=0 and `led`=0. The error is cleared, and the block returns to idle, only when power is turned on or DC is unplugged. In a charging phase or done, losing any start flag, the supply window or the battery type returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one measurement sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Main power of the host is on |
| dc_conn | input | 1 | DC plug detected |
| dc_volt_ok | input | 1 | DC voltage present |
| bat_id_ok | input | 1 | Battery type confirmed |
| vsup_mv | input | 16 | Supply voltage, mV |
| vbat_mv | input | 16 | Battery voltage, mV |
| ibat_ma | input | 16 | Charge current, mA |
| temp_dc | input | 12 | Battery temperature, signed, 0.1 °C |
| isel | output | 3 | Current setpoint: 0 off, 1 trickle 1, 2 trickle 2, 3 quick 666 mA, 4 top-up |
| led | output | 2 | 0 off, 1 single flash, 2 double flash, 3 steady |
| err_code | output | 3 | 0 none, 1 supply, 2 type, 3 timeout, 4 low battery, 5 temperature |

## Verification
The assertions assume that all inputs are known from the moment reset is released, and that every measurement is a new sample taken each clock. The trickle-advance check also assumes that the battery voltage the design acted on is the value it saw one cycle before the move. The stimulus changes inputs only on the falling clock edge. It keeps each directed setting stable for at least the filter length, plus the cycles needed before the next check. It draws the random supply and temperature values around the window edges, so that both the accept side and the reject side of each edge are hit.

// File: rtl/charge_sequencer.sv
module charge_sequencer #(
  parameter int TICK_CYC = 60_000_000,
  parameter int FILT     = 4,
  parameter int T1_MIN   = 3,
  parameter int T2_MIN   = 76,
  parameter int TQ_MIN   = 204,
  parameter int TS_MIN   = 72,
  parameter int TOT_MIN  = 348,
  parameter int VSUP_LO  = 8030,
  parameter int VSUP_HI  = 8800,
  parameter int TST_LO   = -67,
  parameter int TST_HI   = 494,
  parameter int TRUN_LO  = -101,
  parameter int TRUN_HI  = 556,
  parameter int V_TRK2   = 5200,
  parameter int V_QUICK  = 6500,
  parameter int V_LOW    = 5700,
  parameter int I_FULL   = 68,
  parameter int I_TOPUP  = 33
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_on,
  input  logic               dc_conn,
  input  logic               dc_volt_ok,
  input  logic               bat_id_ok,
  input  logic [15:0]        vsup_mv,
  input  logic [15:0]        vbat_mv,
  input  logic [15:0]        ibat_ma,
  input  logic signed [11:0] temp_dc,
  output logic [2:0]         isel,
  output logic [1:0]         led,
  output logic [2:0]         err_code
);
  localparam int PW = $clog2(TICK_CYC + 1);
  localparam int MW = $clog2(T1_MIN + T2_MIN + TQ_MIN + TS_MIN + TOT_MIN + 1);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [15:0] VSL = 16'(VSUP_LO);
  localparam logic [15:0] VSH = 16'(VSUP_HI);
  localparam logic [15:0] VT2 = 16'(V_TRK2);
  localparam logic [15:0] VQK = 16'(V_QUICK);
  localparam logic [15:0] VLW = 16'(V_LOW);
  localparam logic [15:0] IFL = 16'(I_FULL);
  localparam logic [15:0] ITP = 16'(I_TOPUP);
  localparam logic signed [11:0] TSL = 12'(TST_LO);
  localparam logic signed [11:0] TSH = 12'(TST_HI);
  localparam logic signed [11:0] TRL = 12'(TRUN_LO);
  localparam logic signed [11:0] TRH = 12'(TRUN_HI);

  typedef enum logic [2:0] {S_IDLE, S_TRK1, S_TRK2, S_QUICK, S_SUPP, S_DONE, S_ERR} st_t;

  st_t state, nxt, cand, pend;
  logic [2:0] err_q, enxt, ecand, epend;
  logic [FW-1:0] fcnt;
  logic [PW-1:0] ppre, tpre;
  logic [MW-1:0] pmin, tmin, plim;

  wire gate     = !pwr_on && dc_conn && dc_volt_ok;
  wire sup_ok   = vsup_mv >= VSL && vsup_mv <= VSH;
  wire t_start  = temp_dc >= TSL && temp_dc <= TSH;
  wire t_run    = temp_dc >= TRL && temp_dc <= TRH;
  wire charging = state inside {S_TRK1, S_TRK2, S_QUICK, S_SUPP};

  always_comb begin
    cand  = state;
    ecand = 3'd0;
    case (state)
      S_IDLE:
        if (gate) begin
          if (!sup_ok)         begin cand = S_ERR; ecand = 3'd1; end
          else if (!bat_id_ok) begin cand = S_ERR; ecand = 3'd2; end
          else if (t_start)    cand = S_TRK1;
        end
      S_TRK1, S_TRK2, S_QUICK, S_SUPP:
        if (!(gate && sup_ok && bat_id_ok)) cand = S_IDLE;
        else if (!t_run) begin cand = S_ERR; ecand = 3'd5; end
        else if ((state == S_QUICK || state == S_SUPP) && vbat_mv <= VLW) begin
          cand = S_ERR; ecand = 3'd4;
        end
        else case (state)
          S_TRK1:  if (vbat_mv >= VT2) cand = S_TRK2;
          S_TRK2:  if (vbat_mv >= VQK) cand = S_QUICK;
          S_QUICK: if (ibat_ma <= IFL) cand = S_SUPP;
          default: if (ibat_ma <= ITP) cand = S_DONE;
        endcase
      S_DONE:  if (!(gate && sup_ok && bat_id_ok)) cand = S_IDLE;
      S_ERR:   if (pwr_on || !dc_conn) cand = S_IDLE;
      default: cand = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_TRK1:  plim = MW'(T1_MIN);
      S_TRK2:  plim = MW'(T2_MIN);
      S_QUICK: plim = MW'(TQ_MIN);
      S_SUPP:  plim = MW'(TS_MIN);
      default: plim = '0;
    endcase
  end

  wire ptmo   = charging && pmin >= plim;
  wire ttmo   = charging && tmin >= MW'(TOT_MIN);
  wire moving = cand != state;
  wire same   = cand == pend && ecand == epend && fcnt != '0;
  wire commit = moving && (FILT <= 1 || (same && fcnt == FW'(FILT - 1)));

  always_comb begin
    nxt  = state;
    enxt = err_q;
    if (ttmo) begin
      nxt  = (state == S_SUPP) ? S_DONE : S_ERR;
      enxt = (state == S_SUPP) ? 3'd0 : 3'd3;
    end else if (ptmo) begin
      case (state)
        S_QUICK: begin nxt = S_SUPP; enxt = 3'd0; end
        S_SUPP:  begin nxt = S_DONE; enxt = 3'd0; end
        default: begin nxt = S_ERR;  enxt = 3'd3; end
      endcase
    end else if (commit) begin
      nxt  = cand;
      enxt = ecand;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      err_q <= '0;
      pend  <= S_IDLE;
      epend <= '0;
      fcnt  <= '0;
      ppre  <= '0;
      pmin  <= '0;
      tpre  <= '0;
      tmin  <= '0;
    end else begin
      state <= nxt;
      err_q <= enxt;
      pend  <= cand;
      epend <= ecand;
      if (!moving || nxt != state) fcnt <= '0;
      else if (same)               fcnt <= fcnt + 1'b1;
      else                         fcnt <= FW'(1);
      if (!charging || nxt != state) begin
        ppre <= '0; pmin <= '0;
      end else if (ppre == PW'(TICK_CYC - 1)) begin
        ppre <= '0; pmin <= pmin + 1'b1;
      end else ppre <= ppre + 1'b1;
      if (!charging) begin
        tpre <= '0; tmin <= '0;
      end else if (tpre == PW'(TICK_CYC - 1)) begin
        tpre <= '0; tmin <= tmin + 1'b1;
      end else tpre <= tpre + 1'b1;
    end
  end

  always_comb begin
    case (state)
      S_TRK1:  begin isel = 3'd1; led = 2'd1; end
      S_TRK2:  begin isel = 3'd2; led = 2'd1; end
      S_QUICK: begin isel = 3'd3; led = 2'd2; end
      S_SUPP:  begin isel = 3'd4; led = 2'd3; end
      S_DONE:  begin isel = 3'd0; led = 2'd3; end
      default: begin isel = 3'd0; led = 2'd0; end
    endcase
  end
  assign err_code = err_q;

  // R12
  err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 3'd0 |-> isel == 3'd0 && led == 2'd0);
  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_ERR |=> state == S_ERR || state == S_IDLE);
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) == S_IDLE && state == S_TRK1 |->
      $past(!pwr_on && dc_conn && dc_volt_ok && bat_id_ok));
  // R5
  trk_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) == S_TRK1 && state == S_TRK2 |-> $past(vbat_mv) >= VT2);
  // R9
  tot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmin <= MW'(TOT_MIN));
endmodule

// File: tb/test_charge_sequencer.sv
module test_charge_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1, dc_conn = 1'b0, dc_volt_ok = 1'b1, bat_id_ok = 1'b1;
  logic [15:0] vsup = 16'd8400, vbat = 16'd4000, ibat = 16'd400;
  logic signed [11:0] temp = 12'sd250;
  logic [2:0] isel, err_code;
  logic [1:0] led;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  charge_sequencer #(.TICK_CYC(4), .T1_MIN(3), .T2_MIN(5), .TQ_MIN(3),
                     .TS_MIN(4), .TOT_MIN(7)) i_charge_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .dc_conn(dc_conn),
    .dc_volt_ok(dc_volt_ok), .bat_id_ok(bat_id_ok), .vsup_mv(vsup),
    .vbat_mv(vbat), .ibat_ma(ibat), .temp_dc(temp), .isel(isel), .led(led),
    .err_code(err_code));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect3(input string req, input int e_isel, input int e_led, input int e_err);
    chk(req, "isel", int'(isel), e_isel);
    chk(req, "led", int'(led), e_led);
    chk(req, "err_code", int'(err_code), e_err);
  endtask

  task automatic good();
    pwr_on = 0; dc_conn = 1; dc_volt_ok = 1; bat_id_ok = 1;
    vsup = 16'd8400; temp = 12'sd250; ibat = 16'd400;
  endtask

  task automatic park();
    pwr_on = 1; dc_conn = 0;
    cyc(6);
  endtask

  function automatic int exp_err(input logic p, input logic d, input logic dv,
                                 input int vs, input logic ty);
    if (p || !d || !dv) return 0;
    if (vs < 8030 || vs > 8800) return 1;
    if (!ty) return 2;
    return 0;
  endfunction

  function automatic int exp_start(input logic p, input logic d, input logic dv,
                                   input int vs, input int t, input logic ty);
    if (exp_err(p, d, dv, vs, ty) != 0) return 0;
    if (p || !d || !dv || !ty) return 0;
    return (t >= -67 && t <= 494) ? 1 : 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    rst_n = 1;
    cyc(1);
    expect3("R1", 0, 0, 0);

    // R4: three agreeing samples then a break, then four
    good(); vbat = 16'd4000;
    cyc(3);
    chk("R4", "isel after 3 samples", int'(isel), 0);
    pwr_on = 1; cyc(1);
    pwr_on = 0; cyc(3);
    chk("R4", "isel after restart", int'(isel), 0);
    cyc(1);
    expect3("R2", 1, 1, 0);
    park();

    // R2 R3: random start-condition scan
    for (int k = 0; k < 24; k++) begin
      int vs, t;
      case ($urandom_range(0, 5))
        0: vs = 8030; 1: vs = 8800; 2: vs = 8029; 3: vs = 8801;
        4: vs = int'($urandom_range(7500, 9300));
        default: vs = 8400;
      endcase
      case ($urandom_range(0, 5))
        0: t = -67; 1: t = 494; 2: t = -68; 3: t = 495;
        4: t = int'($urandom_range(0, 900)) - 200;
        default: t = 250;
      endcase
      pwr_on = ($urandom_range(0, 5) == 0);
      dc_conn = ($urandom_range(0, 7) != 0);
      dc_volt_ok = ($urandom_range(0, 7) != 0);
      bat_id_ok = ($urandom_range(0, 3) != 0);
      vsup = 16'(vs); temp = 12'(t); vbat = 16'd4000;
      cyc(4);
      chk("R2", "isel scan", int'(isel), exp_start(pwr_on, dc_conn, dc_volt_ok, vs, t, bat_id_ok));
      chk("R3", "err scan", int'(err_code), exp_err(pwr_on, dc_conn, dc_volt_ok, vs, bat_id_ok));
      park();
      chk("R12", "err after unplug", int'(err_code), 0);
      chk("R12", "isel after unplug", int'(isel), 0);
    end

    // R5 R6: full progression at exact thresholds
    good(); vbat = 16'd4000;
    cyc(4); expect3("R2", 1, 1, 0);
    vbat = 16'd5200;
    cyc(3); chk("R4", "still trickle 1", int'(isel), 1);
    cyc(1); expect3("R5", 2, 1, 0);
    vbat = 16'd6500;
    cyc(4); expect3("R5", 3, 2, 0);
    ibat = 16'd69;
    cyc(4); chk("R6", "69 mA stays quick", int'(isel), 3);
    ibat = 16'd68;
    cyc(4); expect3("R6", 4, 3, 0);
    ibat = 16'd33;
    cyc(4); expect3("R6", 0, 3, 0);
    pwr_on = 1;
    cyc(4); expect3("R12", 0, 0, 0);
    park();

    // R10: low battery during quick
    good(); vbat = 16'd6600;
    cyc(12); expect3("R5", 3, 2, 0);
    vbat = 16'd5701;
    cyc(4); chk("R10", "5701 mV stays quick", int'(isel), 3);
    vbat = 16'd5700;
    cyc(4); expect3("R10", 0, 0, 4);
    vbat = 16'd6600;
    cyc(8); expect3("R12", 0, 0, 4);
    dc_conn = 0;
    cyc(4); expect3("R12", 0, 0, 0);
    park();

    // R11: temperature window while charging
    good(); vbat = 16'd5300;
    cyc(8); expect3("R5", 2, 1, 0);
    temp = 12'sd556;
    cyc(6); chk("R11", "556 stays trickle 2", int'(isel), 2);
    temp = 12'sd557;
    cyc(4); expect3("R11", 0, 0, 5);
    pwr_on = 1;
    cyc(4); expect3("R12", 0, 0, 0);
    park();

    // R7: trickle 1 timeout
    good(); vbat = 16'd4000;
    cyc(4);
    cyc(10); chk("R7", "before limit", int'(isel), 1);
    cyc(4); expect3("R7", 0, 0, 3);
    park();

    // R8 R9: quick timeout to top-up, then total timer to done
    good(); vbat = 16'd6600; ibat = 16'd400;
    cyc(4);
    cyc(19); expect3("R8", 3, 2, 0);
    cyc(4);  expect3("R8", 4, 3, 0);
    cyc(8);  expect3("R9", 0, 3, 0);
    park();

    // R9: total timer expiring in quick is an error
    good(); vbat = 16'd4000;
    cyc(4);
    cyc(6); vbat = 16'd5300;
    cyc(4); chk("R5", "trickle 2", int'(isel), 2);
    cyc(10); vbat = 16'd6600;
    cyc(6); expect3("R9", 3, 2, 0);
    cyc(6); expect3("R9", 0, 0, 3);
    park();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule